// File: doc/BRIEF.md
# Burst SRAM Access Start Controller

This block is the clocked front end of a synchronous SRAM whose data bus is shared by reads and writes. On every rising clock it samples three active-low chip selects, two active-low address strobes (one for a processor-side master, one for a controller-side master), a global write, a byte-write enable and four byte-write lines. From these it loads an address register and decides whether the cycle writes or reads. For a write it sends per-lane strobes to a small word array. For a read it drives the bus-enable output.

The two strobes start accesses in different ways. A processor-strobe start only captures the address, and its write inputs are not looked at on that edge. The write decision is taken one clock later. A controller-strobe start writes on the same edge as the strobe, but only when the processor strobe is high. The bus-enable output is dropped as soon as the current write inputs decode a write, whatever the output-enable pin says. The pad logic around the block uses `dq_drive` to switch the shared bus between input and output.

The control is a four-state machine. The states are:
- `ST_IDLE`: deselected, or just out of reset.
- `ST_HOLD`: the address has been loaded by the processor strobe and the write decision is pending.
- `ST_READ`: the held address is being read.
- `ST_WRITE`: the last edge wrote the held address.

The transitions are:
- Start with the processor strobe while selected: any state to `ST_HOLD`.
- Start with the controller strobe while selected: any state to `ST_WRITE` if a write is decoded, otherwise to `ST_READ`.
- A strobe while not selected: any state to `ST_IDLE`.
- No strobe: a non-idle state goes to `ST_WRITE` if a write is decoded, otherwise to `ST_READ`; `ST_IDLE` stays in `ST_IDLE`.

Top module: `burst_sram_front`

## Requirements
- R1: While `rst_n` is low, the state is idle, `dq_drive` is 0, `dq_out` is 0 and every stored word is cleared to zero.
- R2: At a rising edge where `sel_n` is 3'b000 and `pstb_n` is low, `addr` is loaded into the address register and nothing is written, whatever the write inputs are.
- R3: At the edge after a processor-strobe start, if neither strobe is low and a write is decoded, the decoded lanes of `dq_in` are written to the loaded address.
- R4: At a rising edge where `sel_n` is 3'b000, `cstb_n` is low, `pstb_n` is high and a write is decoded, `addr` is loaded and the decoded lanes of `dq_in` are written to `addr` on that same edge.
- R5: When `pstb_n` is low, the state of `cstb_n` has no effect: no write happens on that edge and the next state is `ST_HOLD` (when selected).
- R6: The lane mask is decoded as follows. If `gwr_n` is low, all four lanes are written. Otherwise, if `bwe_n` is low, lane i is written when `lane_n[i]` is low. Otherwise no lane is written. Lane i is `dq_in[8i+7:8i]`, and a write is decoded when the mask is not zero.
- R7: In `ST_HOLD` and `ST_READ`, `dq_out` shows the stored word at the held address, and `dq_drive` is 1 only while `oe_n` is low. In every other case `dq_drive` is 0 and `dq_out` is 0.
- R8: `dq_drive` is 0 in any cycle whose current write inputs decode a write, including a single-lane write and including when `oe_n` is low.
- R9: A strobe edge with any `sel_n` bit high writes nothing, moves the block to `ST_IDLE` and leaves the bus undriven. `ST_IDLE` is left only by a selected strobe.
- R10: In a non-idle state with neither strobe low, a decoded write writes the held address; otherwise the next state is `ST_READ` at the held address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 3 | Chip selects, all must be low to select |
| pstb_n | input | 1 | Processor-side address strobe, active low |
| cstb_n | input | 1 | Controller-side address strobe, active low |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Per-lane byte-write lines, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 32 | Write data from the bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | 32 | Read data toward the bus |
| dq_drive | output | 1 | Bus output enable |

## Verification
The bench attacks the following corner cases, each with a directed sequence, and then runs random traffic against a behavioural reference model:
- A processor-strobe start with the global write held low. A design that wrote on that first edge would corrupt the word that the following read returns.
- Both strobes low together with a write asserted. A design that let the controller strobe win would write when it should not.
- A strobe while one chip select is high. This must leave the bus floating and write nothing.
- A single-lane write during a read with `oe_n` low. A design that did not turn the bus around would drive `dq_drive` high while it should be 0, and one that wrote the wrong lanes would mismatch the reference on the following read.

// File: rtl/burst_front_pkg.sv
package burst_front_pkg;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } front_state_t;
endpackage

// File: rtl/bf_lane_decode.sv
module bf_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_mask
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[l] = !gwr_n || (!bwe_n && !lane_n[l]);
    end

    assert_global_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gwr_n |-> (&lane_mask));
    assert_no_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gwr_n && bwe_n) |-> (lane_mask == '0));
endmodule

// File: rtl/bf_word_store.sv
module bf_word_store #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) bank[w] <= '0;
            end else if (we[l]) begin
                bank[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
    end
endmodule

// File: rtl/bf_ctrl_fsm.sv
module bf_ctrl_fsm
    import burst_front_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel_n,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              read_phase
);
    front_state_t state, state_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic sel, p_go, c_go, wr_hit;

    assign sel    = (sel_n == 3'b000);
    assign p_go   = !pstb_n;
    assign c_go   = !cstb_n && pstb_n;
    assign wr_hit = |lane_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
        end else begin
            state  <= state_nx;
            addr_q <= addr_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        addr_nx   = addr_q;
        mem_we    = '0;
        mem_waddr = addr_q;
        if ((p_go || c_go) && !sel) begin
            state_nx = ST_IDLE;
        end else if (p_go) begin
            state_nx = ST_HOLD;
            addr_nx  = addr;
        end else if (c_go) begin
            addr_nx   = addr;
            mem_waddr = addr;
            mem_we    = lane_mask;
            state_nx  = wr_hit ? ST_WRITE : ST_READ;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_HOLD, ST_READ, ST_WRITE: begin
                    mem_we   = lane_mask;
                    state_nx = wr_hit ? ST_WRITE : ST_READ;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    assign read_phase = (state == ST_HOLD) || (state == ST_READ);

    assert_proc_start_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        p_go |-> (mem_we == '0));
    assert_proc_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && pstb_n && cstb_n) |-> (mem_we == lane_mask && mem_waddr == addr_q));
    assert_ctrl_same_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && c_go) |-> (mem_we == lane_mask && mem_waddr == addr));
    assert_ctrl_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !pstb_n && !cstb_n) |=> (state == ST_HOLD));
    assert_deselect_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((p_go || c_go) && !sel) |=> (state == ST_IDLE && !read_phase));
    assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pstb_n && cstb_n) |-> (mem_we == '0));
endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
    import burst_front_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              sel_n,
    input  logic                    pstb_n,
    input  logic                    cstb_n,
    input  logic                    gwr_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drive
);
    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0]  lane_mask, mem_we;
    logic [ADDR_W-1:0] addr_q, mem_waddr;
    logic [DATA_W-1:0] rd_word;
    logic              read_phase;

    bf_lane_decode #(.LANES(LANES)) u_decode (
        .clk(clk), .rst_n(rst_n), .gwr_n(gwr_n), .bwe_n(bwe_n),
        .lane_n(lane_n), .lane_mask(lane_mask)
    );

    bf_ctrl_fsm #(.ADDR_W(ADDR_W), .LANES(LANES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .pstb_n(pstb_n),
        .cstb_n(cstb_n), .lane_mask(lane_mask), .addr(addr),
        .addr_q(addr_q), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .read_phase(read_phase)
    );

    bf_word_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(dq_in), .raddr(addr_q), .rdata(rd_word)
    );

    assign dq_drive = rst_n && read_phase && !oe_n && (lane_mask == '0);
    assign dq_out   = dq_drive ? rd_word : '0;

    assert_float_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_mask) |-> !dq_drive);
    assert_oe_gates_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> !oe_n);
endmodule

// File: tb/burst_sram_front_bench.sv
module burst_sram_front_bench;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sel_n = 3'b111;
    logic        pstb_n = 1'b1, cstb_n = 1'b1, gwr_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [3:0]  lane_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [31:0] dq_in = '0;
    logic [31:0] dq_out;
    logic        dq_drive;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model: 0 idle, 1 hold, 2 read, 3 write
    int          m_state = 0;
    logic [AW-1:0] m_addr = '0;
    logic [31:0] m_mem [DEPTH];

    always #2 clk = ~clk;

    burst_sram_front u_burst_sram_front (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .pstb_n(pstb_n),
        .cstb_n(cstb_n), .gwr_n(gwr_n), .bwe_n(bwe_n), .lane_n(lane_n),
        .addr(addr), .dq_in(dq_in), .oe_n(oe_n), .dq_out(dq_out),
        .dq_drive(dq_drive)
    );

    function automatic logic [3:0] want_lanes();
        if (!gwr_n) return 4'hF;
        if (!bwe_n) return ~lane_n;
        return 4'h0;
    endfunction

    task automatic model_edge();
        logic [3:0] m = want_lanes();
        bit selected = (sel_n == 3'b000);
        bit pg = !pstb_n;
        bit cg = !cstb_n && pstb_n;
        if ((pg || cg) && !selected) m_state = 0;
        else if (pg) begin m_state = 1; m_addr = addr; end
        else if (cg || m_state != 0) begin
            if (cg) m_addr = addr;
            for (int l = 0; l < 4; l++)
                if (m[l]) m_mem[m_addr][l*8 +: 8] = dq_in[l*8 +: 8];
            m_state = (m != 0) ? 3 : 2;
        end
    endtask

    // inputs already driven after a falling edge; compare, then advance model
    task automatic step(string tag);
        logic exp_drv;
        logic [31:0] exp_dat;
        #1;
        exp_drv = (m_state == 1 || m_state == 2) && !oe_n && (want_lanes() == 0);
        exp_dat = exp_drv ? m_mem[m_addr] : 32'h0;
        checks++;
        if (dq_drive !== exp_drv || dq_out !== exp_dat) begin
            errors++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                     tag, dq_drive, dq_out, exp_drv, exp_dat);
        end
        model_edge();
        @(negedge clk);
    endtask

    task automatic set_in(input logic [2:0] s, input logic p, input logic c,
                          input logic g, input logic b, input logic [3:0] ln,
                          input logic [AW-1:0] a, input logic [31:0] d, input logic o);
        sel_n = s; pstb_n = p; cstb_n = c; gwr_n = g; bwe_n = b;
        lane_n = ln; addr = a; dq_in = d; oe_n = o;
    endtask

    initial begin
        for (int w = 0; w < DEPTH; w++) m_mem[w] = '0;
        repeat (3) @(negedge clk);
        // R1: bus idle during reset even with oe_n low
        #1; checks++;
        if (dq_drive !== 1'b0 || dq_out !== 32'h0) begin
            errors++;
            $display("FAIL R1: drive=%b data=%h expected drive=0 data=0", dq_drive, dq_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        set_in(3'b000, 1, 1, 1, 1, 4'hF, 0, 0, 0); step("R1");
        // R1: fresh word reads zero through a controller read
        set_in(3'b000, 1, 0, 1, 1, 4'hF, 9, 0, 0); step("R1");
        set_in(3'b000, 1, 1, 1, 1, 4'hF, 0, 0, 0); step("R1");
        // R4: controller write same edge, then read back (R10, R7)
        set_in(3'b000, 1, 0, 0, 1, 4'hF, 3, 32'hA1B2C3D4, 0); step("R4");
        set_in(3'b000, 1, 1, 1, 1, 4'hF, 0, 0, 0); step("R10");
        step("R7");
        // R2: processor start with global write low is ignored
        set_in(3'b000, 0, 1, 0, 1, 4'hF, 5, 32'hDEADBEEF, 0); step("R2");
        // R3: byte write lanes 0 and 2 on the next edge
        set_in(3'b000, 1, 1, 1, 0, 4'b1010, 0, 32'h11223344, 0); step("R3");
        set_in(3'b000, 1, 1, 1, 1, 4'hF, 0, 0, 0); step("R3");
        step("R3");
        // R5: both strobes low with write asserted: no write
        set_in(3'b000, 0, 0, 0, 1, 4'hF, 3, 32'h55555555, 0); step("R5");
        set_in(3'b000, 1, 1, 1, 1, 4'hF, 0, 0, 0); step("R5");
        // R9: deselected controller write is dropped, bus floats
        set_in(3'b010, 1, 0, 0, 1, 4'hF, 7, 32'h77777777, 0); step("R9");
        set_in(3'b000, 1, 1, 0, 1, 4'hF, 0, 32'h99999999, 0); step("R9");
        set_in(3'b000, 1, 1, 1, 1, 4'hF, 0, 0, 0); step("R9");
        set_in(3'b000, 1, 0, 1, 1, 4'hF, 7, 0, 0); step("R9");
        set_in(3'b000, 1, 1, 1, 1, 4'hF, 0, 0, 0); step("R9");
        // R8: single-lane write during read with oe_n low floats the bus
        set_in(3'b000, 1, 1, 1, 0, 4'b1011, 0, 32'h00EE0000, 0); step("R8");
        set_in(3'b000, 1, 1, 1, 1, 4'hF, 0, 0, 0); step("R8");
        // R6: enable high with lane lines low writes nothing
        set_in(3'b000, 1, 1, 1, 1, 4'h0, 0, 32'hFFFFFFFF, 0); step("R6");
        set_in(3'b000, 1, 1, 1, 1, 4'hF, 0, 0, 1); step("R7");
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            set_in(($urandom % 8 == 0) ? 3'($urandom) : 3'b000,
                   ($urandom % 5 != 0), ($urandom % 3 != 0),
                   ($urandom % 6 != 0), ($urandom % 2 == 0), 4'($urandom),
                   AW'($urandom), $urandom, ($urandom % 5 == 0));
            step("R7");
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule